// File: doc/BRIEF.md
# Microcoded Action/Condition Sequencer

A controller state machine whose behaviour is held in a small rewritable program memory rather than in fixed logic. A state is a run of consecutive program words that begins at the state's start address. Every word carries an optional action and an optional condition. The word flagged as last closes the list.

On entry to a state, the sequencer first walks the list and emits one single-cycle pulse for each enabled action. Where a word asks for it, the sequencer waits for the matching done input before it moves on. It then freezes every condition input in one snapshot and walks the same list again, comparing conditions against that snapshot. The first word whose condition holds sends the sequencer to its target address, which becomes the new state. If no word in the list matches, the sequencer takes a fresh snapshot and evaluates the list again. It does not repeat any action.

While `halt_i` is high the sequencer is parked at address 0 and the program can be reloaded. Debug outputs show the current state address and the address of the word that caused the most recent transition.

Top module: `cond_sequencer`

## Requirements
- R1: Program word layout (default parameters, W=23 bits): target address [5:0], last-word flag [6], polarity [7], condition index [13:8], condition enable [14], wait-for-done flag [15], action index [21:16], action enable [22].
- R2: In the action phase the sequencer processes one word per cycle, in address order, starting at the state's start address. A word with action enable set raises `act_o[action index]` for exactly one cycle, in the cycle after that word is processed. At most one bit of `act_o` is high at any time. An action index of N_ACT or above emits no pulse.
- R3: A word with both action enable and wait-for-done set emits its pulse and then holds the sequencer until `done_i[action index]` is seen high. Other done bits have no effect. An action index of N_ACT or above completes at once.
- R4: After the last word of the action list, the sequencer spends one cycle copying `cond_i` into a snapshot. It then evaluates the condition words one per cycle from the start address. Evaluation uses only the snapshot, never the live inputs.
- R5: A word with condition enable clear always matches. Otherwise a word matches when snapshot bit [condition index] XOR polarity is 1. A condition index of N_COND or above reads as 0.
- R6: The first matching word in address order wins. Its target becomes the new state, shown on `dbg_state_o`, and the action phase restarts at that address.
- R7: If no word matches up to and including the last word, the sequencer takes a new snapshot and evaluates the list again. No action in that state is issued a second time.
- R8: `dbg_trans_o` holds the address of the word whose condition matched in the most recent transition.
- R9: A program write (`prog_we_i`) takes effect only while `halt_i` is high. A write while the sequencer runs is ignored.
- R10: During reset or while `halt_i` is high, `act_o`, `dbg_state_o` and `dbg_trans_o` are zero. Execution starts at address 0 on the first clock edge at which `halt_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| halt_i | input | 1 | Hold the sequencer at address 0; enables program writes |
| prog_we_i | input | 1 | Program memory write strobe |
| prog_addr_i | input | AW | Program memory write address |
| prog_data_i | input | W | Program word to write |
| done_i | input | N_ACT | Completion flags, one per action |
| cond_i | input | N_COND | Condition inputs |
| act_o | output | N_ACT | One-hot action pulses |
| dbg_state_o | output | AW | Start address of the current state |
| dbg_trans_o | output | AW | Address of the word that caused the last transition |

## Verification
A wrong program counter or phase shows up on `act_o` one cycle later. It appears as a pulse in the wrong slot or order, a missing pulse, or a repeated pulse during re-evaluation. A corrupt snapshot, index decode or polarity shows up on `dbg_state_o` and `dbg_trans_o` within a few cycles of the condition phase: the sequencer lands on the wrong target, or it fails to stay parked. A wait that releases early or never releases is visible as a state change that comes too soon or not at all after the chosen done bit rises.

// File: rtl/cond_seq_pkg.sv
package cond_seq_pkg;
  typedef enum logic [1:0] {
    PH_ACT   = 2'd0,
    PH_WAIT  = 2'd1,
    PH_LATCH = 2'd2,
    PH_COND  = 2'd3
  } seq_phase_e;
endpackage

// File: rtl/cond_seq_mem.sv
module cond_seq_mem #(
  parameter int DEPTH = 64,
  parameter int W     = 23,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_ok_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && wr_ok_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/cond_seq_snap.sv
module cond_seq_snap #(
  parameter int N_COND = 44,
  localparam int CIW   = $clog2(N_COND),
  localparam int NP    = 1 << CIW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [N_COND-1:0] cond_i,
  input  logic              en_i,
  input  logic [CIW-1:0]    idx_i,
  input  logic              pol_i,
  output logic              hit_o
);
  logic [N_COND-1:0] snap_q;
  logic [NP-1:0]     snap_pad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    snap_q <= '0;
    else if (cap_i) snap_q <= cond_i;
  end

  // out-of-range indices read as 0
  always_comb begin
    snap_pad = '0;
    snap_pad[N_COND-1:0] = snap_q;
  end

  assign hit_o = !en_i || (snap_pad[idx_i] ^ pol_i);
endmodule

// File: rtl/cond_seq_pulse.sv
module cond_seq_pulse #(
  parameter int N_ACT = 52,
  localparam int AIW  = $clog2(N_ACT),
  localparam int NP   = 1 << AIW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [AIW-1:0]   idx_i,
  input  logic [N_ACT-1:0] done_i,
  output logic             done_hit_o,
  output logic [N_ACT-1:0] act_o
);
  logic [NP-1:0] done_pad;

  // out-of-range actions complete at once
  always_comb begin
    done_pad = '1;
    done_pad[N_ACT-1:0] = done_i;
  end
  assign done_hit_o = done_pad[idx_i];

  for (genvar g = 0; g < N_ACT; g++) begin : g_act
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) act_o[g] <= 1'b0;
      else         act_o[g] <= fire_i && (idx_i == AIW'(g));
    end
  end
endmodule

// File: rtl/cond_sequencer.sv
module cond_sequencer
  import cond_seq_pkg::*;
#(
  parameter int N_ACT  = 52,
  parameter int N_COND = 44,
  parameter int DEPTH  = 64,
  localparam int AW       = $clog2(DEPTH),
  localparam int AIW      = $clog2(N_ACT),
  localparam int CIW      = $clog2(N_COND),
  localparam int LAST_BIT = AW,
  localparam int POL_BIT  = AW + 1,
  localparam int CIDX_LSB = AW + 2,
  localparam int CEN_BIT  = CIDX_LSB + CIW,
  localparam int WAIT_BIT = CEN_BIT + 1,
  localparam int AIDX_LSB = WAIT_BIT + 1,
  localparam int AEN_BIT  = AIDX_LSB + AIW,
  localparam int W        = AEN_BIT + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic              prog_we_i,
  input  logic [AW-1:0]     prog_addr_i,
  input  logic [W-1:0]      prog_data_i,
  input  logic [N_ACT-1:0]  done_i,
  input  logic [N_COND-1:0] cond_i,
  output logic [N_ACT-1:0]  act_o,
  output logic [AW-1:0]     dbg_state_o,
  output logic [AW-1:0]     dbg_trans_o
);
  seq_phase_e    phase_q;
  logic [AW-1:0] pc_q, base_q, trans_q;
  logic [W-1:0]  word;
  logic          w_aen, w_wait, w_cen, w_pol, w_last;
  logic [AIW-1:0] w_aidx;
  logic [CIW-1:0] w_cidx;
  logic [AW-1:0]  w_tgt;
  logic          fire, cap, hit, done_hit;

  cond_seq_mem #(.DEPTH(DEPTH), .W(W)) i_mem (
    .clk_i   (clk_i),
    .wr_ok_i (halt_i),
    .we_i    (prog_we_i),
    .waddr_i (prog_addr_i),
    .wdata_i (prog_data_i),
    .raddr_i (pc_q),
    .rdata_o (word)
  );

  assign w_tgt  = word[AW-1:0];
  assign w_last = word[LAST_BIT];
  assign w_pol  = word[POL_BIT];
  assign w_cidx = word[CIDX_LSB +: CIW];
  assign w_cen  = word[CEN_BIT];
  assign w_wait = word[WAIT_BIT];
  assign w_aidx = word[AIDX_LSB +: AIW];
  assign w_aen  = word[AEN_BIT];

  assign fire = (phase_q == PH_ACT) && !halt_i && w_aen;
  assign cap  = (phase_q == PH_LATCH) && !halt_i;

  cond_seq_pulse #(.N_ACT(N_ACT)) i_pulse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .idx_i      (w_aidx),
    .done_i     (done_i),
    .done_hit_o (done_hit),
    .act_o      (act_o)
  );

  cond_seq_snap #(.N_COND(N_COND)) i_snap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .cond_i (cond_i),
    .en_i   (w_cen),
    .idx_i  (w_cidx),
    .pol_i  (w_pol),
    .hit_o  (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_ACT;
      pc_q    <= '0;
      base_q  <= '0;
      trans_q <= '0;
    end else if (halt_i) begin
      phase_q <= PH_ACT;
      pc_q    <= '0;
      base_q  <= '0;
      trans_q <= '0;
    end else begin
      unique case (phase_q)
        PH_ACT: begin
          if (w_aen && w_wait) phase_q <= PH_WAIT;
          else if (w_last) begin
            phase_q <= PH_LATCH;
            pc_q    <= base_q;
          end else pc_q <= pc_q + 1'b1;
        end
        PH_WAIT: begin
          if (done_hit) begin
            if (w_last) begin
              phase_q <= PH_LATCH;
              pc_q    <= base_q;
            end else begin
              phase_q <= PH_ACT;
              pc_q    <= pc_q + 1'b1;
            end
          end
        end
        PH_LATCH: phase_q <= PH_COND;
        PH_COND: begin
          if (hit) begin
            base_q  <= w_tgt;
            pc_q    <= w_tgt;
            trans_q <= pc_q;
            phase_q <= PH_ACT;
          end else if (w_last) begin
            // nothing matched: take a fresh snapshot
            phase_q <= PH_LATCH;
            pc_q    <= base_q;
          end else pc_q <= pc_q + 1'b1;
        end
        default: phase_q <= PH_ACT;
      endcase
    end
  end

  assign dbg_state_o = base_q;
  assign dbg_trans_o = trans_q;
endmodule

module cond_sequencer_chk
  import cond_seq_pkg::*;
#(
  parameter int N_ACT = 52,
  parameter int AW    = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             halt_i,
  input logic [N_ACT-1:0] act_o,
  input logic [AW-1:0]    dbg_state_o,
  input logic [AW-1:0]    dbg_trans_o,
  input logic [1:0]       phase_i,
  input logic             done_hit_i
);
  AST_ACT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act_o)); // R2

  AST_PULSE_FROM_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o != '0) |-> ($past(phase_i) == PH_ACT)); // R2

  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_WAIT && !done_hit_i && !halt_i) |=> (phase_i == PH_WAIT)); // R3

  AST_LATCH_TO_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_LATCH && !halt_i) |=> (phase_i == PH_COND)); // R4

  AST_STATE_FROM_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_state_o != $past(dbg_state_o)) |-> ($past(halt_i) || $past(phase_i) == PH_COND)); // R6

  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> (act_o == '0 && dbg_state_o == '0 && dbg_trans_o == '0)); // R10
endmodule

bind cond_sequencer cond_sequencer_chk #(.N_ACT(N_ACT), .AW(AW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .halt_i      (halt_i),
  .act_o       (act_o),
  .dbg_state_o (dbg_state_o),
  .dbg_trans_o (dbg_trans_o),
  .phase_i     (phase_q),
  .done_hit_i  (done_hit)
);

// File: tb/test_cond_sequencer.sv
module test_cond_sequencer;
  localparam int N_ACT  = 52;
  localparam int N_COND = 44;
  localparam int DEPTH  = 64;
  localparam int AW     = 6;
  localparam int W      = 23;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              halt_i = 1'b1;
  logic              prog_we_i = 1'b0;
  logic [AW-1:0]     prog_addr_i = '0;
  logic [W-1:0]      prog_data_i = '0;
  logic [N_ACT-1:0]  done_i = '0;
  logic [N_COND-1:0] cond_i = '0;
  logic [N_ACT-1:0]  act_o;
  logic [AW-1:0]     dbg_state_o;
  logic [AW-1:0]     dbg_trans_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk_i = ~clk_i;

  cond_sequencer #(.N_ACT(N_ACT), .N_COND(N_COND), .DEPTH(DEPTH)) i_cond_sequencer (
    .clk_i(clk_i), .rst_ni(rst_ni), .halt_i(halt_i), .prog_we_i(prog_we_i),
    .prog_addr_i(prog_addr_i), .prog_data_i(prog_data_i), .done_i(done_i),
    .cond_i(cond_i), .act_o(act_o), .dbg_state_o(dbg_state_o), .dbg_trans_o(dbg_trans_o)
  );

  // R1 word layout
  function automatic logic [W-1:0] mk(input bit aen, input int aidx, input bit wt,
                                      input bit cen, input int cidx, input bit pol,
                                      input bit last, input int tgt);
    return {aen, 6'(aidx), wt, cen, 6'(cidx), pol, last, 6'(tgt)};
  endfunction

  function automatic logic [W-1:0] park();
    return mk(0, 0, 0, 1, 63, 0, 1, 0);
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    prog_we_i = 1'b1; prog_addr_i = AW'(a); prog_data_i = d;
    @(negedge clk_i);
    prog_we_i = 1'b0;
  endtask

  task automatic hold();
    halt_i = 1'b1;
    step(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    int cnt;
    logic [N_COND-1:0] c;
    bit bitv, h;
    step(2);
    check("R10 reset act_o", 64'(act_o), 0);
    check("R10 reset dbg_state", 64'(dbg_state_o), 0);
    check("R10 reset dbg_trans", 64'(dbg_trans_o), 0);
    rst_ni = 1'b1;
    step(1);
    wr(10, park());
    wr(20, park());

    // R5 R8 R6: sweep every condition index, polarity and level
    for (int k = 0; k < 64; k++) begin
      for (int p = 0; p < 2; p++) begin
        for (int v = 0; v < 2; v++) begin
          hold();
          wr(0, mk(0, 0, 0, 1, k, p[0], 0, 10));
          wr(1, mk(0, 0, 0, 0, 0, 0, 1, 20));
          for (int b = 0; b < N_COND; b++) c[b] = (b == k) ? v[0] : ~v[0];
          cond_i = c;
          bitv = (k < N_COND) ? v[0] : 1'b0;
          h = bitv ^ p[0];
          halt_i = 1'b0;
          step(8);
          check("R5 R6 target state", 64'(dbg_state_o), h ? 10 : 20);
          check("R8 transition address", 64'(dbg_trans_o), h ? 0 : 1);
        end
      end
    end
    cond_i = '0;

    // R6 first match wins when two words both hold
    hold();
    wr(0, mk(0, 0, 0, 1, 3, 0, 0, 10));
    wr(1, mk(0, 0, 0, 1, 9, 0, 1, 20));
    cond_i = '0; cond_i[3] = 1'b1; cond_i[9] = 1'b1;
    halt_i = 1'b0;
    step(8);
    check("R6 priority state", 64'(dbg_state_o), 10);
    cond_i = '0;

    // R2 single pulse per action index, out-of-range silent
    for (int a = 0; a < 64; a++) begin
      hold();
      wr(0, mk(1, a, 0, 0, 0, 0, 1, 10));
      halt_i = 1'b0;
      step(1);
      check("R2 pulse", 64'(act_o), (a < N_ACT) ? (64'd1 << a) : 64'd0);
      step(1);
      check("R2 pulse ends", 64'(act_o), 0);
    end

    // R2 ordered actions across words
    hold();
    wr(0, mk(1, 5, 0, 1, 63, 0, 0, 0));
    wr(1, mk(1, 9, 0, 1, 63, 0, 0, 0));
    wr(2, mk(1, 11, 0, 0, 0, 0, 1, 10));
    halt_i = 1'b0;
    step(1); check("R2 order first", 64'(act_o), 64'd1 << 5);
    step(1); check("R2 order second", 64'(act_o), 64'd1 << 9);
    step(1); check("R2 order third", 64'(act_o), 64'd1 << 11);
    step(1); check("R2 order idle", 64'(act_o), 0);

    // R3 wait for matching done
    hold();
    wr(0, mk(1, 7, 1, 0, 0, 0, 1, 10));
    done_i = '0;
    halt_i = 1'b0;
    step(1);
    check("R3 wait pulse", 64'(act_o), 64'd1 << 7);
    done_i = ~(52'd1 << 7);
    step(6);
    check("R3 held act_o", 64'(act_o), 0);
    check("R3 held state", 64'(dbg_state_o), 0);
    done_i = 52'd1 << 7;
    step(5);
    check("R3 released state", 64'(dbg_state_o), 10);
    done_i = '0;

    // R4 snapshot: bit seen at latch, gone before evaluation
    hold();
    wr(0, mk(0, 0, 0, 1, 5, 0, 0, 10));
    wr(1, mk(0, 0, 0, 1, 6, 0, 1, 20));
    cond_i = '0; cond_i[5] = 1'b1;
    halt_i = 1'b0;
    step(3);
    cond_i = '0;
    step(5);
    check("R4 snapshot kept", 64'(dbg_state_o), 10);
    check("R8 snapshot trans", 64'(dbg_trans_o), 0);

    // R4 R7 bit rising after latch is ignored until a new snapshot
    hold();
    cond_i = '0;
    halt_i = 1'b0;
    step(3);
    cond_i[6] = 1'b1;
    step(2);
    cond_i = '0;
    step(7);
    check("R4 live change ignored", 64'(dbg_state_o), 0);
    cond_i[6] = 1'b1;
    step(8);
    check("R7 resample state", 64'(dbg_state_o), 20);
    check("R8 resample trans", 64'(dbg_trans_o), 1);
    cond_i = '0;

    // R7 re-evaluation never repeats actions
    hold();
    wr(0, mk(1, 4, 0, 1, 4, 0, 1, 10));
    halt_i = 1'b0;
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      step(1);
      if (act_o[4]) cnt++;
    end
    check("R7 action count", 64'(cnt), 1);
    check("R7 still waiting", 64'(dbg_state_o), 0);
    cond_i[4] = 1'b1;
    step(5);
    check("R7 late match", 64'(dbg_state_o), 10);
    cond_i = '0;

    // R9 write ignored while running
    hold();
    wr(0, mk(0, 0, 0, 0, 0, 0, 1, 10));
    halt_i = 1'b0;
    step(6);
    check("R9 program A", 64'(dbg_state_o), 10);
    wr(0, mk(0, 0, 0, 0, 0, 0, 1, 20));
    hold();
    check("R10 halt clears state", 64'(dbg_state_o), 0);
    halt_i = 1'b0;
    step(6);
    check("R9 running write ignored", 64'(dbg_state_o), 10);
    hold();
    wr(0, mk(0, 0, 0, 0, 0, 0, 1, 20));
    halt_i = 1'b0;
    step(6);
    check("R9 halted write taken", 64'(dbg_state_o), 20);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule